// File: doc/BRIEF.md
# Polled I2C Frame Reader

This block is an I2C target through which a host controller pulls a continuous byte stream, such as lines of text, in fixed blocks of 255 bytes. On one side a producer delivers bytes over a valid/ready handshake into a staging FIFO. On the other side a host reads the block at its 7-bit bus address. Each read returns one frame. A frame carries up to 254 stream bytes in arrival order. The unused positions are filled with line-feed (0x0A) bytes, and the frame always ends with one line-feed. Line-feed is also what the host receives when the stream is empty. Payload is never realigned, so one text line can begin in one frame and end in the next.

A frame is rebuilt only after a read of the current frame has ended with STOP. Assembly takes at most 255 system clocks. A host that leaves a pause of about 2 ms between reads therefore always finds a complete frame. Bus lines are taken in through two-flop synchronizers. The block never stretches the clock. It only pulls SDA low, through an open-drain enable.

Top module: `i2c_frame_reader`

## Requirements
- R1: The block acknowledges only the 7-bit address 0x10. For any other address it leaves SDA released (sda_oe low) through the ninth clock and for the rest of that transaction.
- R2: Read data is shifted out most significant bit first, and SDA changes only while SCL is low. Every read transaction starts at frame byte 0.
- R3: A frame built while enough stream bytes are queued holds the next 254 stream bytes in push order at byte indices 0..253, and 0x0A at index 254.
- R4: If the staging FIFO runs empty during assembly, every remaining position of that frame up to index 254 is 0x0A.
- R5: A frame assembled while no stream byte is pending consists of 0x0A only.
- R6: The stream continues across frames without loss, duplication or reordering, so a sentence may be split between two consecutive frames.
- R7: Reading past index 254 within one transaction returns 0x0A for every further byte until the host NACKs.
- R8: A host NACK followed by STOP ends a read. The unread bytes of that frame are discarded, and the next frame is assembled within 255 system clocks of the detected STOP.
- R9: A read whose START arrives before the current frame is complete returns 0x0A bytes. It neither consumes the frame nor restarts assembly.
- R10: A write to address 0x10 has its address and every data byte acknowledged. The data is dropped, and the transaction does not cause a refill.
- R11: A stream byte is accepted on a clock edge where in_valid and in_ready are both high. in_ready is low exactly when the staging FIFO (default 512 entries) is full.
- R12: After reset sda_oe is low and in_ready is high. The first frame is assembled from reset and is readable once assembly completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Stream byte from the producer |
| in_valid | input | 1 | Producer offers in_data |
| in_ready | output | 1 | Staging FIFO can take a byte |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high (open drain) |

## Verification
A wrong frame index or a stale refill flag shows up at the pins within a single byte of a read. The host receives a payload byte where a line-feed belongs, or the reverse, and the first mismatching byte identifies the failing frame position. A lost or duplicated FIFO pointer appears one frame later, as a break in the continuous stream pattern across a frame boundary. A protocol state that is out of step shows within nine SCL periods, as a missing or extra acknowledge or as SDA driven during another target's transaction.

// File: rtl/i2cfr_pkg.sv
package i2cfr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } bus_st_e;

    localparam logic [7:0] LF_BYTE = 8'h0A;
endpackage

// File: rtl/i2cfr_sync.sv
module i2cfr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl_m1;
        logic scl_m2;
        logic scl_p;
        logic sda_m1;
        logic sda_m2;
        logic sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.scl_m1 = scl_i;
        s_d.scl_m2 = s_q.scl_m1;
        s_d.scl_p  = s_q.scl_m2;
        s_d.sda_m1 = sda_i;
        s_d.sda_m2 = s_q.sda_m1;
        s_d.sda_p  = s_q.sda_m2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.scl_m2;
    assign sda_s     = s_q.sda_m2;
    assign scl_rise  = s_q.scl_m2 & ~s_q.scl_p;
    assign scl_fall  = ~s_q.scl_m2 & s_q.scl_p;
    // data edges while the clock stays high mark bus conditions
    assign start_det = s_q.scl_m2 & s_q.scl_p & s_q.sda_p & ~s_q.sda_m2;
    assign stop_det  = s_q.scl_m2 & s_q.scl_p & ~s_q.sda_p & s_q.sda_m2;
endmodule

// File: rtl/i2cfr_fifo.sv
module i2cfr_fifo #(
    parameter int DEPTH = 512,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] push_data,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW:0]   cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push_fire, pop_fire;

    assign push_ready = (f_q.cnt != FULL_CNT);
    assign empty      = (f_q.cnt == '0);
    assign push_fire  = push_valid & push_ready;
    assign pop_fire   = pop & ~empty;
    assign pop_data   = mem_q[f_q.rptr];

    always_comb begin
        f_d = f_q;
        if (push_fire) f_d.wptr = f_q.wptr + 1'b1;
        if (pop_fire)  f_d.rptr = f_q.rptr + 1'b1;
        case ({push_fire, pop_fire})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push_fire) mem_q[f_q.wptr] <= push_data;
    end

    // R11: occupancy never passes the configured depth
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= FULL_CNT);
    // R11: a full FIFO refuses the next byte and stays full without a pop
    a_r11_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.cnt == FULL_CNT && !pop) |=> f_q.cnt == FULL_CNT);
endmodule

// File: rtl/i2cfr_frame.sv
module i2cfr_frame #(
    parameter int FRAME_LEN  = 255,
    parameter int FIFO_DEPTH = 512,
    parameter int IDX_W      = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             refill_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [7:0]       rd_byte_o,
    output logic             rdy_o
);
    import i2cfr_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] LEN_IDX  = IDX_W'(FRAME_LEN);

    typedef struct packed {
        logic             busy;
        logic             pad;
        logic             rdy;
        logic [IDX_W-1:0] fidx;
    } asm_t;

    asm_t a_d, a_q;
    logic [7:0] mem_q [FRAME_LEN];
    logic       wr_en;
    logic [7:0] wr_byte;
    logic       pop;
    logic [7:0] fifo_data;
    logic       fifo_empty;

    i2cfr_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_data  (in_data),
        .push_valid (in_valid),
        .push_ready (in_ready),
        .pop        (pop),
        .pop_data   (fifo_data),
        .empty      (fifo_empty)
    );

    always_comb begin
        a_d     = a_q;
        wr_en   = 1'b0;
        wr_byte = LF_BYTE;
        pop     = 1'b0;
        if (a_q.busy) begin
            wr_en = 1'b1;
            if (a_q.fidx != LAST_IDX && !a_q.pad && !fifo_empty) begin
                pop     = 1'b1;
                wr_byte = fifo_data;
            end else begin
                a_d.pad = 1'b1;
            end
            if (a_q.fidx == LAST_IDX) begin
                a_d.busy = 1'b0;
                a_d.rdy  = 1'b1;
            end else begin
                a_d.fidx = a_q.fidx + 1'b1;
            end
        end else if (refill_i) begin
            a_d.busy = 1'b1;
            a_d.pad  = 1'b0;
            a_d.rdy  = 1'b0;
            a_d.fidx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '{busy: 1'b1, pad: 1'b0, rdy: 1'b0, fidx: '0};
        else        a_q <= a_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[a_q.fidx] <= wr_byte;
    end

    assign rdy_o     = a_q.rdy;
    assign rd_byte_o = (a_q.rdy && rd_idx_i < LEN_IDX) ? mem_q[rd_idx_i] : LF_BYTE;

    // checker-side cycle count of the running assembly
    logic [IDX_W:0] asm_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         asm_cnt_q <= '0;
        else if (a_q.busy)  asm_cnt_q <= asm_cnt_q + 1'b1;
        else                asm_cnt_q <= '0;
    end

    // R8: assembly never runs longer than FRAME_LEN clocks
    a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.busy |-> asm_cnt_q < (IDX_W+1)'(FRAME_LEN));
    // R3: a completed frame ends with the line-feed terminator
    a_r3_term_lf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_q.rdy) |-> mem_q[FRAME_LEN-1] == LF_BYTE);
    // R9: a refill request during assembly does not restart it
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q.busy && refill_i) |=> a_q.fidx != '0);
endmodule

// File: rtl/i2cfr_target.sv
module i2cfr_target #(
    parameter logic [6:0] ADDR7     = 7'h10,
    parameter int         FRAME_LEN = 255,
    parameter int         IDX_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             rdy_i,
    input  logic [7:0]       rd_byte_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             refill_o,
    output logic             sda_oe_o
);
    import i2cfr_pkg::*;

    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(FRAME_LEN);

    typedef struct packed {
        bus_st_e          st;
        logic [7:0]       sh;
        logic [3:0]       bcnt;
        logic [7:0]       tx;
        logic [IDX_W-1:0] idx;
        logic             tv;
        logic             rd_hit;
        logic             mack;
        logic             oe;
    } tgt_t;

    tgt_t t_d, t_q;
    logic [7:0]       next_byte;
    logic [IDX_W-1:0] idx_inc;

    assign next_byte = t_q.tv ? rd_byte_i : LF_BYTE;
    assign idx_inc   = (t_q.idx == IDX_MAX) ? t_q.idx : t_q.idx + 1'b1;

    always_comb begin
        t_d      = t_q;
        refill_o = 1'b0;
        if (stop_det) begin
            t_d.st     = ST_IDLE;
            t_d.oe     = 1'b0;
            refill_o   = t_q.rd_hit;
            t_d.rd_hit = 1'b0;
        end else if (start_det) begin
            t_d.st   = ST_ADDR;
            t_d.bcnt = '0;
            t_d.oe   = 1'b0;
            t_d.idx  = '0;
            t_d.tv   = rdy_i;
        end else begin
            unique case (t_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        t_d.sh   = {t_q.sh[6:0], sda_s};
                        t_d.bcnt = t_q.bcnt + 1'b1;
                    end
                    if (scl_fall && t_q.bcnt == 4'd8) begin
                        if (t_q.sh[7:1] == ADDR7) begin
                            t_d.st = ST_ADDR_ACK;
                            t_d.oe = 1'b1;
                            if (t_q.sh[0] && t_q.tv) t_d.rd_hit = 1'b1;
                        end else begin
                            t_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        t_d.bcnt = '0;
                        if (t_q.sh[0]) begin
                            t_d.st  = ST_RD;
                            t_d.tx  = next_byte;
                            t_d.idx = idx_inc;
                            t_d.oe  = ~next_byte[7];
                        end else begin
                            t_d.st = ST_WR;
                            t_d.oe = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) t_d.bcnt = t_q.bcnt + 1'b1;
                    if (scl_fall && t_q.bcnt == 4'd8) begin
                        t_d.st = ST_WR_ACK;
                        t_d.oe = 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        t_d.st   = ST_WR;
                        t_d.bcnt = '0;
                        t_d.oe   = 1'b0;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        t_d.bcnt = t_q.bcnt + 1'b1;
                        if (t_q.bcnt == 4'd7) begin
                            t_d.st = ST_RD_ACK;
                            t_d.oe = 1'b0;
                        end else begin
                            t_d.tx = {t_q.tx[6:0], 1'b0};
                            t_d.oe = ~t_q.tx[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) t_d.mack = ~sda_s;
                    if (scl_fall) begin
                        if (t_q.mack) begin
                            t_d.st   = ST_RD;
                            t_d.bcnt = '0;
                            t_d.tx   = next_byte;
                            t_d.idx  = idx_inc;
                            t_d.oe   = ~next_byte[7];
                        end else begin
                            t_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{st: ST_IDLE, default: '0};
        else        t_q <= t_d;
    end

    assign rd_idx_o = t_q.idx;
    assign sda_oe_o = t_q.oe;

    // R2: the target only starts pulling SDA while the clock is low
    a_r2_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);
    // R1: an acknowledge phase is only ever entered for our own address
    a_r1_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == ST_ADDR_ACK) |-> t_q.sh[7:1] == ADDR7);
    // R7: the read index saturates one past the last frame byte
    a_r7_idx_sat: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.idx <= IDX_MAX);
    // R8: a refill request coincides with the end of the transaction
    a_r8_refill_idle: assert property (@(posedge clk) disable iff (!rst_n)
        refill_o |=> t_q.st == ST_IDLE && !t_q.rd_hit);
endmodule

// File: rtl/i2c_frame_reader.sv
module i2c_frame_reader #(
    parameter logic [6:0] ADDR7      = 7'h10,
    parameter int         FRAME_LEN  = 255,
    parameter int         FIFO_DEPTH = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    localparam int IDX_W = $clog2(FRAME_LEN + 1);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             refill, frame_rdy;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_byte;

    i2cfr_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cfr_frame #(.FRAME_LEN(FRAME_LEN), .FIFO_DEPTH(FIFO_DEPTH), .IDX_W(IDX_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .refill_i  (refill),
        .rd_idx_i  (rd_idx),
        .rd_byte_o (rd_byte),
        .rdy_o     (frame_rdy)
    );

    i2cfr_target #(.ADDR7(ADDR7), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdy_i     (frame_rdy),
        .rd_byte_i (rd_byte),
        .rd_idx_o  (rd_idx),
        .refill_o  (refill),
        .sda_oe_o  (sda_oe)
    );
endmodule

// File: tb/i2c_frame_reader_bench.sv
`timescale 1ns/1ps
module i2c_frame_reader_bench;
    localparam int Q    = 6;
    localparam int FLEN = 255;
    localparam logic [7:0] LF = 8'h0A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_frame_reader u_i2c_frame_reader (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe)
    );

    int         checks = 0;
    int         fails = 0;
    bit         quiet = 1'b0;
    bit         done = 1'b0;
    logic [7:0] strm_q[$];
    logic [7:0] exp_frame[FLEN];
    logic [7:0] got[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference frame builder: pop up to 254 bytes, pad, terminate
    task automatic model_refill();
        for (int i = 0; i < FLEN; i++) begin
            if (i < FLEN - 1 && strm_q.size() > 0) exp_frame[i] = strm_q.pop_front();
            else                                   exp_frame[i] = LF;
        end
    endtask

    function automatic logic [7:0] exp_at(input int i);
        return (i < FLEN) ? exp_frame[i] : LF;
    endfunction

    function automatic logic [7:0] gen_byte(input int k);
        int m = k % 40;
        if (m == 38) return 8'h0D;
        if (m == 39) return 8'h0A;
        if (m == 0)  return 8'h24;
        return 8'h41 + 8'(m % 26);
    endfunction

    task automatic push_one(input logic [7:0] b);
        bit acc = 1'b0;
        while (!acc) begin
            in_valid = 1'b1;
            in_data  = b;
            acc      = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0;
        strm_q.push_back(b);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; step(Q);
        sda_m = 1'b0; step(Q);
        scl_m = 1'b0; step(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; step(Q);
        scl_m = 1'b1; step(Q);
        sda_m = 1'b1; step(Q);
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; step(Q);
        scl_m = 1'b1; step(2 * Q);
        scl_m = 1'b0; step(Q);
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; step(Q);
        scl_m = 1'b1; step(Q);
        b = sda_line; step(Q);
        scl_m = 1'b0; step(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_w(b[i]);
        bit_r(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_r(v);
            b[i] = v;
        end
        bit_w(~ack);
    endtask

    task automatic rd_txn(input logic [6:0] a, input int n, output bit aacked);
        logic [7:0] b;
        got.delete();
        bus_start();
        send_byte({a, 1'b1}, aacked);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            got.push_back(b);
        end
        bus_stop();
    endtask

    // quiet-bus monitor: target must not pull SDA on each clock it is watched
    always @(negedge clk) begin
        if (quiet) chk(sda_oe == 1'b0, "R1 foreign address drive", int'(sda_oe), 0);
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            finish_run();
        end
    end

    initial begin
        bit ak;
        int acc_cnt;
        for (int i = 0; i < FLEN; i++) exp_frame[i] = LF;
        step(3);
        chk(sda_oe == 1'b0, "R12 reset sda_oe", int'(sda_oe), 0);
        chk(in_ready == 1'b1, "R12 reset in_ready", int'(in_ready), 1);
        rst_n = 1'b1;

        // R9: read that starts during the reset-time assembly, pushes alongside
        fork
            for (int k = 0; k < 300; k++) push_one(gen_byte(k));
            begin
                step(2);
                rd_txn(7'h10, 3, ak);
            end
        join
        chk(ak, "R1 address ack", int'(ak), 1);
        for (int i = 0; i < 3; i++) chk(got[i] == LF, "R9 early read idle", got[i], LF);

        // R9/R12: reset frame still unread and all line-feed
        step(300);
        rd_txn(7'h10, 4, ak);
        for (int i = 0; i < 4; i++) chk(got[i] == LF, "R9 R12 reset frame", got[i], LF);
        model_refill();

        // R3/R7: full frame plus two bytes past the end
        step(300);
        rd_txn(7'h10, FLEN + 2, ak);
        for (int i = 0; i < FLEN + 2; i++) begin
            if (i < FLEN - 1)  chk(got[i] == exp_at(i), "R3 R2 payload", got[i], exp_at(i));
            else if (i == FLEN - 1) chk(got[i] == LF, "R3 terminator", got[i], LF);
            else               chk(got[i] == LF, "R7 past end", got[i], LF);
        end
        model_refill();

        // R6/R4: stream continues, then padding
        step(300);
        rd_txn(7'h10, 50, ak);
        for (int i = 0; i < 50; i++) begin
            if (i < 46) chk(got[i] == exp_at(i), "R6 continued stream", got[i], exp_at(i));
            else        chk(got[i] == LF, "R4 padding", got[i], LF);
        end
        model_refill();

        // R5: empty stream gives idle bytes
        step(300);
        rd_txn(7'h10, 3, ak);
        for (int i = 0; i < 3; i++) chk(got[i] == LF, "R5 idle frame", got[i], LF);
        model_refill();

        // R10: write transaction is acked and ignored
        push_one(8'h48); push_one(8'h45); push_one(8'h4C); push_one(8'h4C); push_one(8'h4F);
        bus_start();
        send_byte({7'h10, 1'b0}, ak);
        chk(ak, "R10 write address ack", int'(ak), 1);
        send_byte(8'h55, ak);
        chk(ak, "R10 write data ack", int'(ak), 1);
        send_byte(8'hA3, ak);
        chk(ak, "R10 write data ack", int'(ak), 1);
        bus_stop();
        step(300);
        rd_txn(7'h10, 2, ak);
        for (int i = 0; i < 2; i++) chk(got[i] == LF, "R10 no refill by write", got[i], LF);
        model_refill();

        // R1: foreign address not acked, bus left alone
        step(300);
        quiet = 1'b1;
        rd_txn(7'h11, 2, ak);
        quiet = 1'b0;
        chk(!ak, "R1 foreign address nack", int'(ak), 0);

        // R2/R8: read starts at byte 0, partial read discards the rest
        rd_txn(7'h10, 3, ak);
        for (int i = 0; i < 3; i++) chk(got[i] == exp_at(i), "R2 frame start", got[i], exp_at(i));
        model_refill();
        step(300);
        rd_txn(7'h10, 3, ak);
        for (int i = 0; i < 3; i++) chk(got[i] == LF, "R8 unread discarded", got[i], LF);
        model_refill();

        // R11: staging FIFO takes exactly its depth
        step(300);
        acc_cnt = 0;
        for (int k = 0; k < 600; k++) begin
            in_valid = 1'b1;
            in_data  = 8'(k);
            if (in_ready) acc_cnt++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(acc_cnt == 512, "R11 fifo depth", acc_cnt, 512);
        chk(in_ready == 1'b0, "R11 full ready low", int'(in_ready), 0);

        done = 1'b1;
        finish_run();
    end
endmodule